// File: doc/BRIEF.md
# On-Off Backpressure Receiver

This block sits on the receiving end of a link that uses on-off backpressure. It keeps a count of the free slots in the local input buffer. It drives one level signal back to the sender: high means the sender may transmit, low means it must stop. Two strobes drive the count. One marks a flit being written into the buffer, the other marks a flit leaving it. The control level changes only when the state machine changes state, never for each flit. This keeps upstream signalling to a minimum.

Two thresholds with hysteresis decide the level. The stop threshold `OFF_TH` must leave enough free slots to absorb every flit that is already on the wire when the sender sees the stop. The resume threshold `ON_TH` must be high enough that the flits still buffered last until fresh flits arrive after the resume. If either the order `OFF_TH < ON_TH` or the bound `ON_TH <= DEPTH` is broken, elaboration is rejected. The buffer storage, the link and the sender are outside the block.

The controller has two states. In `LINK_ON` the level is high. The transition *throttle* moves it to `LINK_OFF` when the updated free count drops below `OFF_TH`. In `LINK_OFF` the level is low. The transition *release* returns it to `LINK_ON` when the updated free count climbs above `ON_TH`. In every other case the state holds.

Top module: `onoff_rx`

## Requirements
- R1: Reset (asynchronous, active low) sets the free count to `DEPTH` (16 by default), the control level high (state `LINK_ON`) and the overrun flag low.
- R2: On the clock edge that samples them, an arrival alone lowers the free count by one, a departure alone raises it by one, and both together leave it unchanged.
- R3: The throttle transition: while the level is high, the same edge that makes the free count smaller than `OFF_TH` (4 by default) drives the level low.
- R4: The release transition: while the level is low, the same edge that makes the free count greater than `ON_TH` (10 by default) drives the level high.
- R5: When the updated free count lies between `OFF_TH` and `ON_TH`, both bounds included, the level keeps its previous value.
- R6: An arrival without a departure while the free count is 0 leaves the count at 0 and sets the overrun flag. The flag stays high until reset. An arrival and a departure together at a count of 0 do not set it.
- R7: A departure without an arrival while the free count equals `DEPTH` is ignored, and the count stays at `DEPTH`.
- R8: With the default parameters, consider a sender that sees the level two cycles late and whose flits take one more cycle to arrive. Such a sender never overruns the buffer. When the buffer drains at one flit per cycle from full, it never runs empty once the sender resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flit_in | input | 1 | Strobe: one flit written into the buffer this cycle |
| flit_out | input | 1 | Strobe: one flit removed from the buffer this cycle |
| link_on | output | 1 | Control level to the sender, 1 = may send, 0 = stop |
| free_slots | output | $clog2(DEPTH+1) | Current number of free buffer slots |
| overrun | output | 1 | Sticky flag: a flit arrived with no free slot |

## Verification
The assertions only take for granted that both strobes carry known values on every sampled edge. Arrivals at an empty buffer and departures from a full one are legal inputs here, and the properties cover them. The vector table drives both of these misuse cases on purpose, and the link-delay test drives departures only when the buffer is occupied. The properties on level and thresholds therefore hold for any strobe pattern. The link scenario uses a sender model that follows the lagged level, so the stimulus can check that the thresholds suit the default round trip.

// File: rtl/onoff_pkg.sv
package onoff_pkg;
    typedef enum logic {
        LINK_OFF = 1'b0,
        LINK_ON  = 1'b1
    } link_state_e;
endpackage

// File: rtl/slot_tracker.sv
module slot_tracker #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          give,
    output logic [CW-1:0] free_q,
    output logic [CW-1:0] free_d,
    output logic          overrun_hit
);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);
    localparam logic [CW-1:0] ONE  = CW'(1);

    // next free count, saturating at both ends
    always_comb begin
        free_d      = free_q;
        overrun_hit = 1'b0;
        if (take && !give) begin
            if (free_q == '0) overrun_hit = 1'b1;
            else              free_d = free_q - ONE;
        end else if (give && !take) begin
            if (free_q != FULL) free_d = free_q + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) free_q <= FULL;
        else        free_q <= free_d;
    end
endmodule

// File: rtl/hyst_ctrl.sv
module hyst_ctrl
    import onoff_pkg::*;
#(
    parameter int CW     = 5,
    parameter int OFF_TH = 4,
    parameter int ON_TH  = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] free_d,
    output logic          level
);
    localparam logic [CW-1:0] OFF_V = CW'(OFF_TH);
    localparam logic [CW-1:0] ON_V  = CW'(ON_TH);

    link_state_e state_q, state_n;

    // next-state logic: throttle and release
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            LINK_ON:  if (free_d < OFF_V) state_n = LINK_OFF;
            LINK_OFF: if (free_d > ON_V)  state_n = LINK_ON;
            default:  state_n = LINK_ON;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LINK_ON;
        else        state_q <= state_n;
    end

    // output decode
    always_comb begin
        unique case (state_q)
            LINK_ON:  level = 1'b1;
            LINK_OFF: level = 1'b0;
            default:  level = 1'b1;
        endcase
    end
endmodule

// File: rtl/overrun_latch.sv
module overrun_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   flag <= 1'b0;
        else if (hit) flag <= 1'b1;
    end
endmodule

// File: rtl/onoff_rx.sv
module onoff_rx #(
    parameter int DEPTH  = 16,
    parameter int OFF_TH = 4,
    parameter int ON_TH  = 10,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flit_in,
    input  logic          flit_out,
    output logic          link_on,
    output logic [CW-1:0] free_slots,
    output logic          overrun
);
    generate
        if (ON_TH <= OFF_TH || ON_TH > DEPTH || OFF_TH < 1) begin : g_bad_th
            $error("onoff_rx: need 1 <= OFF_TH < ON_TH <= DEPTH");
        end
    endgenerate

    logic [CW-1:0] free_d;
    logic          hit;

    slot_tracker #(.DEPTH(DEPTH), .CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .take(flit_in), .give(flit_out),
        .free_q(free_slots), .free_d(free_d), .overrun_hit(hit)
    );

    hyst_ctrl #(.CW(CW), .OFF_TH(OFF_TH), .ON_TH(ON_TH)) u_fsm (
        .clk(clk), .rst_n(rst_n), .free_d(free_d), .level(link_on)
    );

    overrun_latch u_ovr (
        .clk(clk), .rst_n(rst_n), .hit(hit), .flag(overrun)
    );
endmodule

// File: rtl/onoff_rx_chk.sv
module onoff_rx_chk #(
    parameter int DEPTH  = 16,
    parameter int OFF_TH = 4,
    parameter int ON_TH  = 10,
    parameter int CW     = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flit_in,
    input logic          flit_out,
    input logic          link_on,
    input logic [CW-1:0] free_slots,
    input logic          overrun
);
    localparam logic [CW-1:0] FULL  = CW'(DEPTH);
    localparam logic [CW-1:0] OFF_V = CW'(OFF_TH);
    localparam logic [CW-1:0] ON_V  = CW'(ON_TH);
    localparam logic [CW-1:0] ONE   = CW'(1);

    a_r1_range: assert property (@(posedge clk) disable iff (!rst_n)
        free_slots <= FULL);
    a_r2_arrive_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_in && !flit_out && free_slots != '0) |=> free_slots == $past(free_slots) - ONE);
    a_r2_depart_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_out && !flit_in && free_slots != FULL) |=> free_slots == $past(free_slots) + ONE);
    a_r2_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_in && flit_out) |=> $stable(free_slots));
    a_r3_low_off: assert property (@(posedge clk) disable iff (!rst_n)
        (free_slots < OFF_V) |-> !link_on);
    a_r4_high_on: assert property (@(posedge clk) disable iff (!rst_n)
        (free_slots > ON_V) |-> link_on);
    a_r5_band_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(link_on) |-> (free_slots < OFF_V || free_slots > ON_V));
    a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_in && !flit_out && free_slots == '0) |=> (overrun && free_slots == '0));
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    a_r7_full_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (flit_out && !flit_in && free_slots == FULL) |=> free_slots == FULL);
endmodule

bind onoff_rx onoff_rx_chk #(.DEPTH(DEPTH), .OFF_TH(OFF_TH), .ON_TH(ON_TH)) u_chk (
    .clk(clk), .rst_n(rst_n), .flit_in(flit_in), .flit_out(flit_out),
    .link_on(link_on), .free_slots(free_slots), .overrun(overrun)
);

// File: tb/tb_onoff_rx.sv
module tb_onoff_rx;
    localparam int DEPTH = 16;
    localparam int CW    = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flit_in = 1'b0;
    logic          flit_out = 1'b0;
    logic          link_on;
    logic [CW-1:0] free_slots;
    logic          overrun;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #10 clk = ~clk;  // 50 MHz

    onoff_rx dut (
        .clk(clk), .rst_n(rst_n), .flit_in(flit_in), .flit_out(flit_out),
        .link_on(link_on), .free_slots(free_slots), .overrun(overrun)
    );

    typedef struct packed {
        logic [4:0] rep;
        logic       a;
        logic       d;
        logic [4:0] free;
        logic       go;
        logic       ovf;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{5'd1,  1'b0, 1'b1, 5'd16, 1'b1, 1'b0},  // R7 departure at full ignored
        '{5'd1,  1'b1, 1'b1, 5'd16, 1'b1, 1'b0},  // R2 both
        '{5'd1,  1'b1, 1'b0, 5'd15, 1'b1, 1'b0},  // R2 arrival
        '{5'd11, 1'b1, 1'b0, 5'd4,  1'b1, 1'b0},  // R5 at OFF_TH still on
        '{5'd1,  1'b1, 1'b0, 5'd3,  1'b0, 1'b0},  // R3 throttle
        '{5'd1,  1'b1, 1'b1, 5'd3,  1'b0, 1'b0},  // R2 both
        '{5'd1,  1'b0, 1'b1, 5'd4,  1'b0, 1'b0},  // R2 departure, R5 held off
        '{5'd6,  1'b0, 1'b1, 5'd10, 1'b0, 1'b0},  // R5 at ON_TH still off
        '{5'd1,  1'b0, 1'b1, 5'd11, 1'b1, 1'b0},  // R4 release
        '{5'd1,  1'b1, 1'b0, 5'd10, 1'b1, 1'b0},  // R5 held on in band
        '{5'd6,  1'b1, 1'b0, 5'd4,  1'b1, 1'b0},  // R5
        '{5'd1,  1'b1, 1'b0, 5'd3,  1'b0, 1'b0},  // R3
        '{5'd3,  1'b1, 1'b0, 5'd0,  1'b0, 1'b0},  // R2 down to empty
        '{5'd1,  1'b1, 1'b1, 5'd0,  1'b0, 1'b0},  // R6 both at zero: no overrun
        '{5'd1,  1'b1, 1'b0, 5'd0,  1'b0, 1'b1},  // R6 overrun set
        '{5'd1,  1'b0, 1'b1, 5'd1,  1'b0, 1'b1},  // R6 sticky
        '{5'd1,  1'b0, 1'b0, 5'd1,  1'b0, 1'b1}   // R6 sticky, idle
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input logic a, input logic d);
        flit_in  = a;
        flit_out = d;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <= 5000 cycles", cycles);
            summary();
        end
    end

    initial begin
        logic p1, p2;
        int   starve, min_free;
        @(negedge clk);
        @(negedge clk);
        chk("R1 reset free", free_slots, 16);
        chk("R1 reset level", link_on, 1);
        chk("R1 reset overrun", overrun, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk
        for (int i = 0; i < NV; i++) begin
            for (int k = 0; k < VEC[i].rep; k++) step(VEC[i].a, VEC[i].d);
            chk($sformatf("vec%0d free", i), free_slots, VEC[i].free);
            chk($sformatf("vec%0d level", i), link_on, VEC[i].go);
            chk($sformatf("vec%0d overrun", i), overrun, VEC[i].ovf);
        end
        step(1'b0, 1'b0);

        // R1: reset from off/overrun state
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 re-reset free", free_slots, 16);
        chk("R1 re-reset level", link_on, 1);
        chk("R1 re-reset overrun", overrun, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: sender sees level two cycles late, flits take one more
        p1 = 1'b0; p2 = 1'b0; min_free = DEPTH;
        for (int c = 0; c < 40; c++) begin
            flit_in  = p2;
            flit_out = 1'b0;
            p2 = p1;
            p1 = link_on;
            @(negedge clk);
            if (free_slots < min_free) min_free = free_slots;
        end
        chk("R8 fill no overrun", overrun, 0);
        chk("R8 fill lowest free", min_free, 1);
        chk("R8 level off when full", link_on, 0);
        starve = 0;
        for (int c = 0; c < 60; c++) begin
            if (free_slots == DEPTH) starve++;
            flit_in  = p2;
            flit_out = (free_slots != DEPTH);
            p2 = p1;
            p1 = link_on;
            @(negedge clk);
        end
        chk("R8 drain never empty", starve, 0);
        chk("R8 drain no overrun", overrun, 0);
        chk("R8 level on while draining", link_on, 1);
        flit_in = 1'b0;
        flit_out = 1'b0;
        summary();
    end
endmodule